// File: doc/BRIEF.md
# Pulse-Density Half-Bridge Gate Driver

This block drives the two gates of a half-bridge resonant converter from a first-order, one-bit delta-sigma loop. A fast system clock is divided down to the switching rate. Once per switching period the loop adds the difference between a run-time reference and a signed feedback term to a signed accumulator. The accumulator's sign is the one-bit decision for the next period.

When the decision is 1, the high-side and low-side gates toggle in complementary halves of the period. When it is 0, the bridge is parked for the whole period: high side off, low side on. The fraction of running periods tracks the reference, scaled by the gain, so the converter's power is set by pulse density. It still switches only at its resonant frequency.

The gate phase is a copy of the switching square wave, delayed by a few system-clock cycles. This lets the updated decision settle before any gate edge. The reference and gain are read only in the last system-clock cycle of each period.

Top module: `dsm_gate_driver`

## Requirements
- R1: While `rst` is high, both gate outputs are low and the accumulator is cleared, so `decision` reads 1. Both gates stay low in the first cycle after `rst` falls.
- R2: The gain used by the loop is `gain_in` limited to the range 1..GMAX; inputs below 1 use 1. The reference used is `ref_in` limited to the range from minus the used gain to plus the used gain. Both inputs are signed two's complement, DW bits wide.
- R3: The accumulator always stays within -2*GMAX .. 2*GMAX-1, whatever sequence of inputs is applied.
- R4: `decision` is 1 when the accumulator is zero or positive, and 0 when it is negative.
- R5: At the end of every period the accumulator gains (reference - feedback). The feedback is +gain when `decision` is 1 and -gain when it is 0.
- R6: `ref_in` and `gain_in` affect the loop only through their values in the last cycle of a period. Values held in any other cycle have no effect.
- R7: With the reference equal to +gain, `decision` is 1 in every period. With the reference equal to -gain, it is 1 in the first period after reset and 0 in every later one.
- R8: In a period with `decision` = 1, `hs_gate` is high in period cycles PHASE_DLY .. PHASE_DLY+DIV/2-1 (cycle 0 being the first cycle of the period) and low in the others. `ls_gate` is the complement of `hs_gate`.
- R9: In a period with `decision` = 0, `hs_gate` is low and `ls_gate` is high throughout.
- R10: Over N periods from reset with constant inputs, let the count of 1 decisions be n, the used gain G and the used reference r. Then |2*G*n - N*(r+G)| ≤ 2*G.
- R11: A period lasts DIV system-clock cycles. `decision` changes only between the last cycle of one period and the first cycle of the next. The first period starts in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | DW | Signed reference (pulse-density target) |
| gain_in | input | DW | Signed feedback gain |
| hs_gate | output | 1 | High-side gate drive |
| ls_gate | output | 1 | Low-side gate drive |
| decision | output | 1 | Current one-bit quantizer decision |

## Verification
Inputs are read at the clock edge that ends a period, and the accumulator register updates on that same edge. The new decision therefore appears in cycle 0 of the next period, and the bench advances its model only at its sample in period cycle DIV-1.

The gates lag the square wave by PHASE_DLY registers, including the output register. The bench therefore expects `hs_gate` high when the period cycle minus PHASE_DLY, taken modulo DIV, is below DIV/2. It compares every cycle at the falling edge.

Wild reference and gain values are held in mid-period cycles and removed before the period-end edge. Any sampling outside that edge would diverge from the model.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Datapath width of reference, gain, feedback and accumulator.
    localparam int DW = 12;

    typedef logic signed [DW-1:0] sval_t;

    // Quantizer decision: run the bridge or park it.
    typedef enum logic {
        DEC_PARK = 1'b0,
        DEC_RUN  = 1'b1
    } dec_e;

    // Operands the loop uses in one period update.
    typedef struct packed {
        sval_t gain;
        sval_t refv;
    } loop_opnd_t;

    localparam sval_t S_ONE = sval_t'(1);

    // Limit the gain to 1..gmax.
    function automatic sval_t limit_gain(sval_t g, sval_t gmax);
        if (g < S_ONE) return S_ONE;
        if (g > gmax)  return gmax;
        return g;
    endfunction

    // Limit the reference to -g..+g (g is already positive).
    function automatic sval_t limit_ref(sval_t r, sval_t g);
        if (r > g)  return g;
        if (r < -g) return -g;
        return r;
    endfunction

endpackage

// File: rtl/dsm_rate_gen.sv
module dsm_rate_gen #(
    parameter int DIV       = 150,
    parameter int PHASE_DLY = 3
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic dphase
);
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam int STG  = PHASE_DLY - 1;

    logic [CW-1:0]  cnt;
    logic           sw_clk;
    logic [STG-1:0] dly;

    assign tick   = (cnt == CW'(DIV - 1));
    assign sw_clk = (cnt < CW'(HALF));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Delay line for the switching square wave.
    always_ff @(posedge clk) begin
        if (rst) begin
            dly <= '0;
        end else begin
            dly[0] <= sw_clk;
            for (int i = 1; i < STG; i++) begin
                dly[i] <= dly[i-1];
            end
        end
    end

    assign dphase = dly[STG-1];

endmodule

// File: rtl/dsm_loop.sv
module dsm_loop
    import dsm_pkg::*;
#(
    parameter int GMAX = 1023
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  sval_t ref_in,
    input  sval_t gain_in,
    output sval_t acc,
    output dec_e  dec
);
    localparam sval_t GLIM = sval_t'(GMAX);

    loop_opnd_t op;
    sval_t      fb;
    sval_t      delta;

    always_comb begin
        op.gain = limit_gain(gain_in, GLIM);
        op.refv = limit_ref(ref_in, op.gain);
        fb      = (dec == DEC_RUN) ? op.gain : -op.gain;
        delta   = op.refv - fb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (tick) begin
            acc <= acc + delta;
        end
    end

    assign dec = acc[DW-1] ? DEC_PARK : DEC_RUN;

endmodule

// File: rtl/dsm_gate_out.sv
module dsm_gate_out
    import dsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dec_e dec,
    input  logic dphase,
    output logic hs_gate,
    output logic ls_gate
);
    logic hs_next;

    assign hs_next = (dec == DEC_RUN) && dphase;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_gate <= 1'b0;
            ls_gate <= 1'b0;
        end else begin
            hs_gate <= hs_next;
            ls_gate <= !hs_next;
        end
    end

endmodule

// File: rtl/dsm_gate_driver.sv
module dsm_gate_driver
    import dsm_pkg::*;
#(
    parameter int DIV       = 150,
    parameter int PHASE_DLY = 3,
    parameter int GMAX      = 1023
) (
    input  logic              clk,
    input  logic              rst,
    input  logic signed [DW-1:0] ref_in,
    input  logic signed [DW-1:0] gain_in,
    output logic              hs_gate,
    output logic              ls_gate,
    output logic              decision
);
    logic  tick;
    logic  dphase;
    sval_t acc;
    dec_e  dec;

    dsm_rate_gen #(
        .DIV       (DIV),
        .PHASE_DLY (PHASE_DLY)
    ) u_rate (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .dphase (dphase)
    );

    dsm_loop #(
        .GMAX (GMAX)
    ) u_loop (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ref_in  (ref_in),
        .gain_in (gain_in),
        .acc     (acc),
        .dec     (dec)
    );

    dsm_gate_out u_gate (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .dphase  (dphase),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );

    assign decision = (dec == DEC_RUN);

endmodule

// File: rtl/dsm_gate_checker.sv
module dsm_gate_checker
    import dsm_pkg::*;
#(
    parameter int GMAX = 1023
) (
    input logic  clk,
    input logic  rst,
    input logic  hs_gate,
    input logic  ls_gate,
    input logic  decision,
    input logic  tick,
    input sval_t acc
);
    localparam sval_t ACC_LO = sval_t'(-2 * GMAX);
    localparam sval_t ACC_HI = sval_t'(2 * GMAX - 1);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_gates_off_r1: assert property (@(posedge clk)
        rst |=> (!hs_gate && !ls_gate));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (acc >= ACC_LO) && (acc <= ACC_HI));

    p_complement_r8: assert property (@(posedge clk) disable iff (rst)
        armed |-> (hs_gate ^ ls_gate));

    p_parked_r9: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(!decision)) |-> (!hs_gate && ls_gate));

    p_boundary_r11: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(tick)) |-> $stable(decision));

endmodule

bind dsm_gate_driver dsm_gate_checker #(
    .GMAX (GMAX)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hs_gate  (hs_gate),
    .ls_gate  (ls_gate),
    .decision (decision),
    .tick     (tick),
    .acc      (acc)
);

// File: tb/sim_dsm_gate_driver.sv
module sim_dsm_gate_driver;
    localparam int DIV  = 8;
    localparam int DLY  = 2;
    localparam int GMAX = 1023;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [11:0] ref_in  = '0;
    logic signed [11:0] gain_in = 12'sd1;
    logic hs_gate, ls_gate, decision;

    int errs   = 0;
    int checks = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    dsm_gate_driver #(
        .DIV       (DIV),
        .PHASE_DLY (DLY),
        .GMAX      (GMAX)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (ref_in),
        .gain_in  (gain_in),
        .hs_gate  (hs_gate),
        .ls_gate  (ls_gate),
        .decision (decision)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=%0d expected<190000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int used_gain(int g);
        if (g < 1)    return 1;
        if (g > GMAX) return GMAX;
        return g;
    endfunction

    function automatic int used_ref(int r, int g);
        if (r > g)  return g;
        if (r < -g) return -g;
        return r;
    endfunction

    // One reset followed by nper periods with nominal inputs.
    task automatic run_cfg(input int r_nom, input int g_nom, input int nper);
        int acc_m;
        int ones;
        int x4;
        int k;
        int exp_hs;
        int g_u;
        int r_u;
        int diff;

        @(negedge clk);
        rst     = 1'b1;
        ref_in  = 12'(r_nom);
        gain_in = 12'(g_nom);
        @(negedge clk);
        chk("R1 hs_gate in reset", int'(hs_gate), 0);
        chk("R1 ls_gate in reset", int'(ls_gate), 0);
        @(negedge clk);
        chk("R1 decision after clear", int'(decision), 1);
        rst   = 1'b0;
        acc_m = 0;
        ones  = 0;

        for (int c = 1; c < nper * DIV; c++) begin
            @(negedge clk);
            k  = c % DIV;
            x4 = (acc_m >= 0) ? 1 : 0;
            if (k == 1) ones += int'(decision);
            chk("R4 R5 R11 decision", int'(decision), x4);
            exp_hs = (x4 == 1 && ((k - DLY + DIV) % DIV) < HALF) ? 1 : 0;
            if (x4 == 1) begin
                chk("R8 hs_gate running", int'(hs_gate), exp_hs);
                chk("R8 ls_gate running", int'(ls_gate), 1 - exp_hs);
            end else begin
                chk("R9 hs_gate parked", int'(hs_gate), 0);
                chk("R9 ls_gate parked", int'(ls_gate), 1);
            end
            if (k == DIV - 1) begin
                g_u   = used_gain(int'(gain_in));
                r_u   = used_ref(int'(ref_in), g_u);
                acc_m = acc_m + r_u - ((x4 == 1) ? g_u : -g_u);
            end
            // R6: wild values held mid-period only.
            if ((k + 1) % DIV == 3 || (k + 1) % DIV == 4) begin
                ref_in  = -12'sd2000;
                gain_in = 12'sd7;
            end else begin
                ref_in  = 12'(r_nom);
                gain_in = 12'(g_nom);
            end
        end

        g_u  = used_gain(g_nom);
        r_u  = used_ref(r_nom, g_u);
        diff = 2 * g_u * ones - nper * (r_u + g_u);
        if (diff < 0) diff = -diff;
        chk("R10 pulse density bound", (diff <= 2 * g_u) ? 1 : 0, 1);
        if (r_u == g_u)  chk("R7 full reference ones", ones, nper);
        else if (r_u == -g_u) chk("R7 negative full reference ones", ones, 1);
    endtask

    initial begin
        int glist [5] = '{1, 2, 3, 5, 15};
        foreach (glist[i]) begin
            for (int r = -glist[i] - 2; r <= glist[i] + 2; r++) begin
                run_cfg(r, glist[i], 4 * glist[i] + 2);
            end
        end
        // R2: gain limits at both ends.
        run_cfg(300, 2000, 10);
        run_cfg(5, 0, 10);
        run_cfg(-3, -9, 10);
        run_cfg(-1023, 1023, 6);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule